// File: doc/BRIEF.md
# Clock Controller Register Bank

This block holds the configuration words of a clock control unit behind a plain 32-bit read/write strobe bus. A bus master addresses it by byte offset inside a 4 KB window. Every access is a full aligned word. Each implemented word is also driven out in parallel, so the downstream clock generation, divider and gating logic can use it directly.

Each word has a fixed reset value. A write stores the data through that word's own mask, so undefined bits always stay zero. The mode word also has one bit that every write forces to one. Several words are read-only from the bus. The block raises a one-cycle error strobe in the cycle of any access it refuses: an unaligned offset, an offset past the last word, or a write to a read-only word. Read data is registered and appears one cycle after the strobe.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset, word k is located at byte offset 4*k. The reset values are: mode (k=0) 0x074B0B7D, divider A (k=1) 0xFF870B48, divider B (k=2) 0x49FCFE7F, reset status (k=3) 0x007F0000, core PLL (k=4) 0x04001800, USB PLL (k=5) 0x04051C03, serial PLL (k=6) 0x04043001, clock-out select (k=7) 0x00000280, gate masks (k=8,9,10) and wake mask (k=11) 0xFFFFFFFF, tracking 1 (k=18) 0x00004040, power A (k=23) 0x80209828, power B (k=24) 0x00AA0000, divider C (k=25) 0x00000285, and every other word (k=12..17, 19..22) zero.
- R2: A read strobe to an aligned offset with index below 26 returns the stored word on rdata_o one cycle later, with err_o low.
- R3: A read strobe to an unaligned offset (addr_i[1:0] not 0), or to an index of 26 or more, returns zero on rdata_o one cycle later and raises err_o in the strobe cycle.
- R4: A write to the mode word stores (wdata_i & 0x3B6FDFFF) with bit 26 set to one, whatever the data.
- R5: A write to divider A stores wdata_i & 0xFF9F3FFF.
- R6: A write to the core PLL or to the serial PLL stores wdata_i & 0xBFFF3FFF.
- R7: A write to divider B or to any of the three gate masks stores all 32 bits of wdata_i.
- R8: A write to any other word, or to an unaligned or out-of-range offset, changes no stored word and raises err_o in the strobe cycle.
- R9: err_o is high only in a strobe cycle of a refused access. It is low for accepted accesses and for idle cycles.
- R10: regs_o bits [32k+31:32k] always carry word k, and they change in the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Refused-access strobe, same cycle as req_i |
| regs_o | output | 832 | All 26 words, word k at bits [32k+31:32k] |

## Verification
Several properties are checked on every cycle: the error strobe never appears without an access, refused reads return zero, the forced mode bit stays at one, read-only words hold through writes, PLL writes take the PLL mask, and valid reads return the word that was present at the strobe. Only the bench scenarios can show the full list of reset values, the mask of each writable word under all-ones, all-zeros and alternating data, and that errors occur at every read-only index and at the top of the window.

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
  parameter int NREG = 26,
  parameter int AW   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               err_o,
  output logic [NREG*32-1:0] regs_o
);
  localparam int IW        = AW - 2;
  localparam int FORCE_BIT = 26;

  function automatic logic [31:0] rst_val(input int k);
    case (k)
      0:             return 32'h074B0B7D;
      1:             return 32'hFF870B48;
      2:             return 32'h49FCFE7F;
      3:             return 32'h007F0000;
      4:             return 32'h04001800;
      5:             return 32'h04051C03;
      6:             return 32'h04043001;
      7:             return 32'h00000280;
      8, 9, 10, 11:  return 32'hFFFFFFFF;
      18:            return 32'h00004040;
      23:            return 32'h80209828;
      24:            return 32'h00AA0000;
      25:            return 32'h00000285;
      default:       return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] wr_mask(input int k);
    case (k)
      0:             return 32'h3B6FDFFF;
      1:             return 32'hFF9F3FFF;
      4, 6:          return 32'hBFFF3FFF;
      2, 8, 9, 10:   return 32'hFFFFFFFF;
      default:       return 32'h0;
    endcase
  endfunction

  function automatic logic writable(input int k);
    return (k == 0) || (k == 1) || (k == 2) || (k == 4) || (k == 6) ||
           (k == 8) || (k == 9) || (k == 10);
  endfunction

  logic [31:0]   words [NREG];
  logic [31:0]   rd_word;
  logic          wr_ok;
  logic [IW-1:0] idx;
  logic          hit;

  assign idx = addr_i[AW-1:2];
  assign hit = (addr_i[1:0] == 2'b00) && (int'(idx) < NREG);

  always_comb begin
    rd_word = '0;
    wr_ok   = 1'b0;
    for (int k = 0; k < NREG; k++) begin
      if (idx == IW'(k)) begin
        rd_word = words[k];
        wr_ok   = writable(k);
      end
    end
  end

  assign err_o = req_i && (!hit || (we_i && !wr_ok));

  for (genvar g = 0; g < NREG; g++) begin : g_word
    localparam logic [31:0] FORCE = (g == 0) ? (32'h1 << FORCE_BIT) : 32'h0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[g] <= rst_val(g);
      else if (req_i && we_i && hit && writable(g) && idx == IW'(g))
        words[g] <= (wdata_i & wr_mask(g)) | FORCE;
    end
    assign regs_o[g*32 +: 32] = words[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_o <= '0;
    else if (req_i && !we_i)
      rdata_o <= hit ? rd_word : '0;
  end
endmodule

module clkctl_regbank_chk #(
  parameter int NREG = 26,
  parameter int AW   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_i,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic               err_o,
  input logic [NREG*32-1:0] regs_o
);
  logic        bad;
  logic [31:0] sel_word;
  assign bad      = (addr_i[1:0] != 2'b00) || (int'(addr_i[AW-1:2]) >= NREG);
  assign sel_word = 32'(regs_o >> (32 * int'(addr_i[AW-1:2])));

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> req_i); // R9
  AST_BAD_READ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && bad) |-> err_o); // R3
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && bad) |=> (rdata_o == 32'h0)); // R3
  AST_GOOD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && !bad) |=> (rdata_o == $past(sel_word))); // R2
  AST_MODE_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[26]); // R4
  AST_USBPLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == AW'(5 * 4)) |=> $stable(regs_o[5*32 +: 32])); // R8
  AST_USBPLL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == AW'(5 * 4)) |-> err_o); // R8
  AST_PLL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && we_i && addr_i == AW'(4 * 4)) |=>
      (regs_o[4*32 +: 32] == ($past(wdata_i) & 32'hBFFF3FFF))); // R6
endmodule

bind clkctl_regbank clkctl_regbank_chk #(.NREG(NREG), .AW(AW)) u_chk (.*);

// File: tb/test_clkctl_regbank.sv
`timescale 1ns/100ps
module test_clkctl_regbank;
  localparam int NREG = 26;
  localparam int AW   = 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_i = 1'b0;
  logic               we_i = 1'b0;
  logic [AW-1:0]      addr_i = '0;
  logic [31:0]        wdata_i = '0;
  logic [31:0]        rdata_o;
  logic               err_o;
  logic [NREG*32-1:0] regs_o;

  clkctl_regbank #(.NREG(NREG), .AW(AW)) i_clkctl_regbank (.*);

  always #2.5 clk = ~clk;

  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [31:0] model [NREG];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rv(input int k);
    case (k)
      0: return 32'h074B0B7D;   1: return 32'hFF870B48;
      2: return 32'h49FCFE7F;   3: return 32'h007F0000;
      4: return 32'h04001800;   5: return 32'h04051C03;
      6: return 32'h04043001;   7: return 32'h00000280;
      8, 9, 10, 11: return 32'hFFFFFFFF;
      18: return 32'h00004040;  23: return 32'h80209828;
      24: return 32'h00AA0000;  25: return 32'h00000285;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int k);
    case (k)
      0: return 32'h3B6FDFFF;   1: return 32'hFF9F3FFF;
      4, 6: return 32'hBFFF3FFF;
      2, 8, 9, 10: return 32'hFFFFFFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(input int k);
    case (k)
      0: return "R4";  1: return "R5";  4, 6: return "R6";
      2, 8, 9, 10: return "R7";  default: return "R8";
    endcase
  endfunction

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                        input string req);
    int  k;
    bit  bad;
    bit  refused;
    k       = int'(a[AW-1:2]);
    bad     = (a[1:0] != 2'b00) || (k >= NREG);
    refused = bad || (w && mk(k) == 32'h0);
    @(negedge clk);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    if (!w) begin
      exp_q.push_back(bad ? 32'h0 : model[k]);
      tag_q.push_back(bad ? "R3" : "R2");
    end
    #1 check(refused ? (bad ? "R3 err" : "R8 err") : "R9 no err", {31'h0, err_o}, {31'h0, refused});
    if (w && !refused) model[k] = (d & mk(k)) | ((k == 0) ? 32'h04000000 : 32'h0);
    @(posedge clk);
    #1 req_i = 1'b0; we_i = 1'b0;
    #0.5 check("R9 idle", {31'h0, err_o}, 32'h0);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NREG; k++) check(req, regs_o[k*32 +: 32], model[k]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && req_i && !we_i) begin
        @(negedge clk);
        check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'hFFFFFFFF; pats[1] = 32'h00000000; pats[2] = 32'hA5A5_5A5A;
    for (int k = 0; k < NREG; k++) model[k] = rv(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    check("R3 reset rdata", rdata_o, 32'h0);
    for (int k = 0; k < NREG; k++) access(1'b0, AW'(k * 4), 32'h0, "R2");
    access(1'b0, AW'(NREG * 4), 32'h0, "R3");
    access(1'b0, 12'hFFC, 32'h0, "R3");
    access(1'b0, 12'h006, 32'h0, "R3");
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < NREG; k++) begin
        access(1'b1, AW'(k * 4), pats[p] ^ 32'(k), rtag(k));
        check(rtag(k), regs_o[k*32 +: 32], model[k]);
        access(1'b0, AW'(k * 4), 32'h0, "R2");
      end
      check_all("R10 export");
    end
    access(1'b1, 12'h001, 32'h0, "R8");
    access(1'b1, 12'hFFC, 32'h12345678, "R8");
    access(1'b1, AW'(NREG * 4), 32'h0, "R8");
    check_all("R8 untouched");
    access(1'b1, 12'h000, 32'h0, "R4");
    check("R4 forced bit", regs_o[31:0], 32'h04000000);
    done = 1;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule